// File: doc/BRIEF.md
# MEI Cache Snoop Response Unit

This block answers bus snoops for a cache that keeps only three line states: Modified, Exclusive and Invalid. For every address transfer seen on the shared bus it takes the per-way hit vector and line states from the tag lookup, picks the matching way, and one cycle later drives the wire-ORed snoop response. It also issues the tag-state change the snoop calls for and, when a Modified line is hit, asks the data path to push that line out to memory.

Because no line is ever Shared, the shared-hit response is never driven. A global snoop that hits an Exclusive line invalidates it at once. The only exception is a read by a master that will not cache the data, which leaves the line untouched. A global snoop that hits a Modified line is retried and starts a push. When the push completes, the line goes to Invalid, or to Exclusive for a non-caching read. Non-global transfers are watched but never change state.

The snoop input has no ready line, because the bus cannot be stalled: address retry is the only back-pressure. The push request is a valid/ready stream. Once `push_valid` rises, `push_set` and `push_addr` hold until a cycle with `push_ready` high completes the transfer. While a push is outstanding, any global snoop that hits a valid line is retried and takes no action. Tag RAM and data movement are outside this block.

Top module: `snoop_resp_unit`

## Requirements
- R1: Every sampled snoop (`snp_valid` high at a rising edge) produces `rsp_valid` high for exactly the following cycle, with `rsp_retry` and `rsp_set` for that snoop; without a snoop, `rsp_valid` is low.
- R2: A snoop with `snp_collide` high gets `rsp_retry` in its response cycle, and it neither starts a push nor updates a line.
- R3: A global snoop whose selected way is Modified (state code 2) gets `rsp_retry`. With no push pending, `push_valid` rises in the response cycle with `push_set` equal to the way and `push_addr` equal to the snooped address.
- R4: A global snoop of kind read (0), read-for-ownership (1) or write (3) that selects an Exclusive way (state code 1) gives `upd_valid` in the response cycle with `upd_state` Invalid (0) and `upd_set` equal to the way, and no retry.
- R5: A global non-caching read (kind 2) that hits Exclusive causes neither retry nor update. If it hits Modified it is retried and pushed, and after the push the update sets the line to Exclusive (1).
- R6: In the cycle after a push handshake (`push_valid` and `push_ready` high at an edge), `upd_valid` is high with `upd_set` equal to the pushed way and `upd_state` Invalid (0), or Exclusive (1) for kind 2; `push_valid` is low in that cycle.
- R7: A non-global snoop (`snp_global` low) never starts a push or produces an update, and it is retried only on a collision.
- R8: `rsp_shared` is low at all times.
- R9: The set code of way i is i in binary (00, 01, 10, 11 for four ways). A way counts as a hit only if its hit bit is set and its state is Exclusive or Modified; among several hits the lowest way wins. A snoop with no hit gets set code 0 and no retry, except on a collision.
- R10: While `push_valid` is high and `push_ready` low, `push_valid`, `push_set` and `push_addr` stay unchanged. A global snoop that hits during that time is retried without an update, and a global snoop that misses is not retried.
- R11: During reset `rsp_valid`, `rsp_retry`, `upd_valid` and `push_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| snp_valid | input | 1 | Address transfer present this cycle |
| snp_kind | input | 2 | Transfer kind: 0 read, 1 read-for-ownership, 2 non-caching read, 3 write |
| snp_global | input | 1 | Transfer must be snooped for coherence |
| snp_addr | input | AW | Snooped block address |
| snp_hit | input | WAYS | Per-way tag match |
| snp_state | input | 2*WAYS | Per-way line state, way i in bits 2i+1:2i (0 I, 1 E, 2 M) |
| snp_collide | input | 1 | Pipeline collision on this snoop |
| rsp_valid | output | 1 | Snoop response cycle |
| rsp_retry | output | 1 | Address retry response |
| rsp_shared | output | 1 | Shared-hit response, held low |
| rsp_set | output | SW | Set code of the selected way |
| upd_valid | output | 1 | Tag state write strobe |
| upd_set | output | SW | Way to write |
| upd_state | output | 2 | New line state |
| push_valid | output | 1 | Push request for a Modified line |
| push_ready | input | 1 | Data path accepts the push |
| push_set | output | SW | Way to push |
| push_addr | output | AW | Address of the line to push |

## Verification
Some rules hold on every cycle and are checked that way. These are the one-cycle response timing, retry on collision, silence of non-global snoops, holding of the push request under back-pressure, the update that follows every push handshake, and the absence of any update toward Modified. Other behaviour depends on which way is selected and on the kind of transfer, so only the bench scenarios show it. This covers lowest-way priority, hits on Invalid lines being ignored, the set-code values, Exclusive invalidation against non-caching reads, and the final state a push leaves behind.

// File: rtl/snoop_pkg.sv
package snoop_pkg;

  typedef enum logic [1:0] {
    LS_INV  = 2'd0,
    LS_EXCL = 2'd1,
    LS_MOD  = 2'd2,
    LS_RSVD = 2'd3
  } line_state_e;

  typedef enum logic [1:0] {
    XK_READ        = 2'd0,
    XK_READ_OWN    = 2'd1,
    XK_READ_NOFILL = 2'd2,
    XK_WRITE       = 2'd3
  } xfer_kind_e;

  function automatic logic state_is_valid(line_state_e s);
    return (s == LS_EXCL) || (s == LS_MOD);
  endfunction

endpackage

// File: rtl/snoop_way_pick.sv
module snoop_way_pick
  import snoop_pkg::*;
#(
  parameter int WAYS = 4,
  parameter int SW   = 2
) (
  input  logic [WAYS-1:0]   hit,
  input  logic [2*WAYS-1:0] state,
  output logic              found,
  output logic [SW-1:0]     way_idx,
  output line_state_e       way_state
);

  logic [WAYS-1:0] live_hit;
  line_state_e     st_arr [WAYS];

  // A tag match on an Invalid line is not a hit.
  for (genvar g = 0; g < WAYS; g++) begin : g_way
    assign st_arr[g]   = line_state_e'(state[2*g +: 2]);
    assign live_hit[g] = hit[g] && state_is_valid(st_arr[g]);
  end

  // Lowest index wins: scan from the top so the lowest hit is written last.
  always_comb begin
    found     = 1'b0;
    way_idx   = '0;
    way_state = LS_INV;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (live_hit[w]) begin
        found     = 1'b1;
        way_idx   = SW'(w);
        way_state = st_arr[w];
      end
    end
  end

endmodule

// File: rtl/snoop_decide.sv
module snoop_decide
  import snoop_pkg::*;
(
  input  logic        valid,
  input  xfer_kind_e  kind,
  input  logic        global_xfer,
  input  logic        collide,
  input  logic        busy,
  input  logic        found,
  input  line_state_e way_state,
  output logic        retry,
  output logic        inval_now,
  output logic        push_start,
  output logic        keep_line
);

  logic hit_mod;
  logic hit_excl;
  logic act;

  assign hit_mod  = found && (way_state == LS_MOD);
  assign hit_excl = found && (way_state == LS_EXCL);

  // Only a global, collision-free hit with no push outstanding takes action.
  assign act = valid && global_xfer && found && !collide && !busy;

  always_comb begin
    retry = 1'b0;
    if (valid) begin
      if (collide) retry = 1'b1;
      else if (global_xfer && found && (busy || hit_mod)) retry = 1'b1;
    end
  end

  assign keep_line  = (kind == XK_READ_NOFILL);
  assign inval_now  = act && hit_excl && !keep_line;
  assign push_start = act && hit_mod;

endmodule

// File: rtl/snoop_push_ctl.sv
module snoop_push_ctl #(
  parameter int AW = 32,
  parameter int SW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [SW-1:0] start_set,
  input  logic [AW-1:0] start_addr,
  input  logic          start_keep,
  input  logic          push_ready,
  output logic          push_valid,
  output logic [SW-1:0] push_set,
  output logic [AW-1:0] push_addr,
  output logic          done,
  output logic [SW-1:0] done_set,
  output logic          done_keep
);

  logic keep_q;

  assign done      = push_valid && push_ready;
  assign done_set  = push_set;
  assign done_keep = keep_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      push_valid <= 1'b0;
      push_set   <= '0;
      push_addr  <= '0;
      keep_q     <= 1'b0;
    end else if (done) begin
      push_valid <= 1'b0;
    end else if (start && !push_valid) begin
      push_valid <= 1'b1;
      push_set   <= start_set;
      push_addr  <= start_addr;
      keep_q     <= start_keep;
    end
  end

endmodule

// File: rtl/snoop_resp_unit.sv
module snoop_resp_unit
  import snoop_pkg::*;
#(
  parameter  int WAYS = 4,
  parameter  int AW   = 32,
  localparam int SW   = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              snp_valid,
  input  logic [1:0]        snp_kind,
  input  logic              snp_global,
  input  logic [AW-1:0]     snp_addr,
  input  logic [WAYS-1:0]   snp_hit,
  input  logic [2*WAYS-1:0] snp_state,
  input  logic              snp_collide,
  output logic              rsp_valid,
  output logic              rsp_retry,
  output logic              rsp_shared,
  output logic [SW-1:0]     rsp_set,
  output logic              upd_valid,
  output logic [SW-1:0]     upd_set,
  output logic [1:0]        upd_state,
  output logic              push_valid,
  input  logic              push_ready,
  output logic [SW-1:0]     push_set,
  output logic [AW-1:0]     push_addr
);

  logic          found;
  logic [SW-1:0] way_idx;
  line_state_e   way_state;
  logic          retry_d;
  logic          inval_now;
  logic          push_start;
  logic          keep_line;
  logic          done;
  logic [SW-1:0] done_set;
  logic          done_keep;

  snoop_way_pick #(.WAYS(WAYS), .SW(SW)) u_pick (
    .hit       (snp_hit),
    .state     (snp_state),
    .found     (found),
    .way_idx   (way_idx),
    .way_state (way_state)
  );

  snoop_decide u_decide (
    .valid       (snp_valid),
    .kind        (xfer_kind_e'(snp_kind)),
    .global_xfer (snp_global),
    .collide     (snp_collide),
    .busy        (push_valid),
    .found       (found),
    .way_state   (way_state),
    .retry       (retry_d),
    .inval_now   (inval_now),
    .push_start  (push_start),
    .keep_line   (keep_line)
  );

  snoop_push_ctl #(.AW(AW), .SW(SW)) u_push (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (push_start),
    .start_set  (way_idx),
    .start_addr (snp_addr),
    .start_keep (keep_line),
    .push_ready (push_ready),
    .push_valid (push_valid),
    .push_set   (push_set),
    .push_addr  (push_addr),
    .done       (done),
    .done_set   (done_set),
    .done_keep  (done_keep)
  );

  // No Shared state exists, so the shared-hit line is never driven.
  assign rsp_shared = 1'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_retry <= 1'b0;
      rsp_set   <= '0;
    end else begin
      rsp_valid <= snp_valid;
      rsp_retry <= retry_d;
      rsp_set   <= (snp_valid && found) ? way_idx : '0;
    end
  end

  // Push completion and immediate invalidation never coincide: a push
  // outstanding blocks every action of a new snoop.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      upd_valid <= 1'b0;
      upd_set   <= '0;
      upd_state <= LS_INV;
    end else begin
      upd_valid <= inval_now || done;
      if (done) begin
        upd_set   <= done_set;
        upd_state <= done_keep ? LS_EXCL : LS_INV;
      end else begin
        upd_set   <= way_idx;
        upd_state <= LS_INV;
      end
    end
  end

endmodule

// File: rtl/snoop_resp_unit_chk.sv
module snoop_resp_unit_chk #(
  parameter  int WAYS = 4,
  parameter  int AW   = 32,
  localparam int SW   = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          snp_valid,
  input logic          snp_global,
  input logic          snp_collide,
  input logic          rsp_valid,
  input logic          rsp_retry,
  input logic          upd_valid,
  input logic [1:0]    upd_state,
  input logic          push_valid,
  input logic          push_ready,
  input logic [SW-1:0] push_set,
  input logic [AW-1:0] push_addr
);

  AST_RSP_AFTER_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |=> rsp_valid);  // R1
  AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !snp_valid |=> !rsp_valid);  // R1
  AST_COLLIDE_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_collide) |=> rsp_retry);  // R2
  AST_COLLIDE_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_collide && !push_valid) |=> !push_valid);  // R2
  AST_LOCAL_NO_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && !snp_global && !(push_valid && push_ready)) |=> !upd_valid);  // R7
  AST_LOCAL_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && !snp_global && !push_valid) |=> !push_valid);  // R7
  AST_PUSH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !push_ready) |=> (push_valid && $stable(push_set) && $stable(push_addr)));  // R10
  AST_PUSH_DONE_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && push_ready) |=> (upd_valid && !push_valid));  // R6
  AST_UPD_NOT_MOD: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> (upd_state == 2'd0 || upd_state == 2'd1));  // R6

endmodule

bind snoop_resp_unit snoop_resp_unit_chk #(.WAYS(WAYS), .AW(AW)) u_chk (.*);

// File: tb/snoop_resp_unit_bench.sv
module snoop_resp_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 12;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        snp_valid;
  logic [1:0]  snp_kind;
  logic        snp_global;
  logic [31:0] snp_addr;
  logic [3:0]  snp_hit;
  logic [7:0]  snp_state;
  logic        snp_collide;
  logic        rsp_valid, rsp_retry, rsp_shared;
  logic [1:0]  rsp_set;
  logic        upd_valid;
  logic [1:0]  upd_set, upd_state;
  logic        push_valid, push_ready;
  logic [1:0]  push_set;
  logic [31:0] push_addr;

  int checks   = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  snoop_resp_unit u_snoop_resp_unit (.*);

  // {kind[2], global, collide, hit[4], state[8], retry, set[2], upd_now, push, final[2]}
  localparam logic [22:0] VEC [NVEC] = '{
    {2'd0, 1'b1, 1'b0, 4'b0001, 8'b00_00_00_01, 1'b0, 2'd0, 1'b1, 1'b0, 2'd0}, // R4 read, E way0
    {2'd1, 1'b1, 1'b0, 4'b0100, 8'b00_10_00_00, 1'b1, 2'd2, 1'b0, 1'b1, 2'd0}, // R3 R6 own, M way2
    {2'd2, 1'b1, 1'b0, 4'b0010, 8'b00_00_01_00, 1'b0, 2'd1, 1'b0, 1'b0, 2'd0}, // R5 nofill, E way1
    {2'd2, 1'b1, 1'b0, 4'b1000, 8'b10_00_00_00, 1'b1, 2'd3, 1'b0, 1'b1, 2'd1}, // R5 nofill, M way3
    {2'd3, 1'b1, 1'b0, 4'b1000, 8'b01_00_00_00, 1'b0, 2'd3, 1'b1, 1'b0, 2'd0}, // R4 write, E way3
    {2'd0, 1'b0, 1'b0, 4'b0010, 8'b00_00_10_00, 1'b0, 2'd1, 1'b0, 1'b0, 2'd0}, // R7 local, M way1
    {2'd0, 1'b1, 1'b1, 4'b0001, 8'b00_00_00_10, 1'b1, 2'd0, 1'b0, 1'b0, 2'd0}, // R2 collide, M way0
    {2'd0, 1'b0, 1'b1, 4'b0000, 8'b00_00_00_00, 1'b1, 2'd0, 1'b0, 1'b0, 2'd0}, // R2 R7 local collide
    {2'd0, 1'b1, 1'b0, 4'b0110, 8'b00_01_00_00, 1'b0, 2'd2, 1'b1, 1'b0, 2'd0}, // R9 way1 Invalid skipped
    {2'd1, 1'b1, 1'b0, 4'b1100, 8'b01_01_00_00, 1'b0, 2'd2, 1'b1, 1'b0, 2'd0}, // R9 lowest wins
    {2'd0, 1'b1, 1'b0, 4'b0000, 8'b00_00_00_00, 1'b0, 2'd0, 1'b0, 1'b0, 2'd0}, // R9 miss
    {2'd1, 1'b1, 1'b0, 4'b0010, 8'b00_00_10_00, 1'b1, 2'd1, 1'b0, 1'b1, 2'd0}  // R3 own, M way1
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_snoop(input logic [1:0] k, input logic g, input logic c,
                             input logic [3:0] h, input logic [7:0] s, input logic [31:0] a);
    snp_valid   = 1'b1;
    snp_kind    = k;
    snp_global  = g;
    snp_collide = c;
    snp_hit     = h;
    snp_state   = s;
    snp_addr    = a;
  endtask

  task automatic idle_inputs();
    snp_valid   = 1'b0;
    snp_kind    = 2'd0;
    snp_global  = 1'b0;
    snp_collide = 1'b0;
    snp_hit     = '0;
    snp_state   = '0;
    snp_addr    = '0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n      = 1'b0;
    push_ready = 1'b0;
    idle_inputs();
    repeat (3) @(negedge clk);
    check("R11 rsp_valid", rsp_valid, 0);
    check("R11 rsp_retry", rsp_retry, 0);
    check("R11 upd_valid", upd_valid, 0);
    check("R11 push_valid", push_valid, 0);
    check("R8 shared in reset", rsp_shared, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle no response", rsp_valid, 0);

    for (int i = 0; i < NVEC; i++) begin
      logic [22:0] v;
      logic [31:0] a;
      v = VEC[i];
      a = 32'h1000 + 32'(i) * 32'h40;
      drive_snoop(v[22:21], v[20], v[19], v[18:15], v[14:7], a);
      @(negedge clk);
      idle_inputs();
      check("R1 rsp_valid", rsp_valid, 1);
      check("R2 R3 R9 rsp_retry", rsp_retry, v[6]);
      check("R9 rsp_set", rsp_set, v[5:4]);
      check("R8 rsp_shared", rsp_shared, 0);
      check("R4 R5 R7 upd_valid", upd_valid, v[3]);
      if (v[3]) begin
        check("R4 upd_state", upd_state, 0);
        check("R4 upd_set", upd_set, v[5:4]);
      end
      check("R3 R7 push_valid", push_valid, v[2]);
      if (v[2]) begin
        check("R3 push_set", push_set, v[5:4]);
        check("R3 push_addr", push_addr, a);
        push_ready = 1'b1;
        @(negedge clk);
        push_ready = 1'b0;
        check("R6 upd_valid after push", upd_valid, 1);
        check("R6 R5 upd_state after push", upd_state, v[1:0]);
        check("R6 upd_set after push", upd_set, v[5:4]);
        check("R6 push_valid cleared", push_valid, 0);
      end
      @(negedge clk);
      check("R1 response lasts one cycle", rsp_valid, 0);
    end

    // R10: back-pressure on the push stream
    drive_snoop(2'd1, 1'b1, 1'b0, 4'b0010, 8'b00_00_10_00, 32'hABC0);
    @(negedge clk);
    idle_inputs();
    check("R10 push raised", push_valid, 1);
    @(negedge clk);
    @(negedge clk);
    check("R10 push held", push_valid, 1);
    check("R10 push_set held", push_set, 1);
    check("R10 push_addr held", push_addr, 32'hABC0);
    drive_snoop(2'd0, 1'b1, 1'b0, 4'b0001, 8'b00_00_00_01, 32'h2000);
    @(negedge clk);
    idle_inputs();
    check("R10 hit while busy retried", rsp_retry, 1);
    check("R10 hit while busy no update", upd_valid, 0);
    check("R10 push_addr unchanged", push_addr, 32'hABC0);
    drive_snoop(2'd0, 1'b1, 1'b0, 4'b0000, 8'b00_00_00_00, 32'h3000);
    @(negedge clk);
    idle_inputs();
    check("R10 miss while busy not retried", rsp_retry, 0);
    push_ready = 1'b1;
    @(negedge clk);
    push_ready = 1'b0;
    check("R6 update after held push", upd_valid, 1);
    check("R6 state Invalid after held push", upd_state, 0);
    check("R6 set after held push", upd_set, 1);
    @(negedge clk);
    check("R6 single update strobe", upd_valid, 0);

    // R10: ready without a pending push does nothing
    push_ready = 1'b1;
    @(negedge clk);
    push_ready = 1'b0;
    check("R10 stray ready no update", upd_valid, 0);
    check("R10 stray ready no push", push_valid, 0);

    // R11: reset mid-push clears the request
    drive_snoop(2'd0, 1'b1, 1'b0, 4'b0001, 8'b00_00_00_10, 32'h4000);
    @(negedge clk);
    idle_inputs();
    check("R3 push before reset", push_valid, 1);
    rst_n = 1'b0;
    @(negedge clk);
    check("R11 push cleared by reset", push_valid, 0);
    check("R11 response cleared by reset", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule